// File: doc/BRIEF.md
# 64-bit Integer Execute Unit with Word Operations

This block is the integer execute stage of a 64-bit core. Each cycle it may accept one already-decoded operation: an operation select, two 64-bit operands (the second can be replaced by a sign-extended 12-bit immediate), a 20-bit upper immediate and the address of the instruction. One cycle later it presents the 64-bit result together with a valid flag.

It covers full-width addition, subtraction and the three shift kinds. It also covers their 32-bit word counterparts, which look only at the low half of each operand and return a sign-extended 32-bit value. Two more operations are included: building a constant from an upper immediate, and adding that constant to the instruction address. The only handshake is a valid bit. Nothing stalls the unit.

Operation select encoding (`op_sel`): 0 add, 1 subtract, 2 shift left, 3 logical right shift, 4 arithmetic right shift, 5 word add, 6 word subtract, 7 word shift left, 8 word logical right shift, 9 word arithmetic right shift, 10 upper-immediate constant, 11 upper immediate plus address. Codes 12 to 15 produce zero.

Top module: `int_exec_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. Reset drives `out_valid`, `reserved` and `result` to zero.
- R2: Full-width add and subtract (codes 0, 1) return the 64-bit sum or difference modulo 2^64.
- R3: Full-width shifts (codes 2, 3, 4) take their amount from bits 5:0 of the second operand. A logical shift fills the vacated bits with zeros. An arithmetic right shift fills them with operand bit 63.
- R4: Word operations (codes 5 to 9) ignore operand bits 63:32. Result bits 63 down to 31 all equal result bit 31.
- R5: Word add and subtract discard overflow and return the low 32 bits of the sum or difference, sign-extended.
- R6: Word shifts take their amount from second-operand bits 4:0. The word arithmetic right shift fills with bit 31 of the first operand.
- R7: When `use_imm` is 1, the second operand is `imm12` sign-extended from bit 11. For right-shift codes (3, 4, 8, 9) with `use_imm` set, `imm12[10]` selects an arithmetic shift (1) or a logical shift (0).
- R8: Code 10 returns `imm20` placed in bits 31:12, with zeros below, sign-extended from bit 31.
- R9: Code 11 returns that same sign-extended value plus `pc`, modulo 2^64.
- R10: A word add with `use_imm` set and `imm12` equal to zero returns the sign-extension of `src_a[31:0]`.
- R11: `reserved` is high with the result of a word shift (codes 7, 8, 9) issued with `use_imm` set and `imm12[5]` equal to 1. It is low for every other operation. The result of such an operation is undefined.
- R12: In a cycle without `in_valid`, `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 4 | Operation select (encoding above) |
| use_imm | input | 1 | Use sign-extended `imm12` as second operand |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second register operand |
| imm12 | input | 12 | Short immediate |
| imm20 | input | 20 | Upper immediate |
| pc | input | 64 | Address of the instruction |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Registered result |
| reserved | output | 1 | Reserved word-shift immediate encoding seen |

## Verification
The embedded properties assume that `op_sel` is always one of the twelve defined codes when `in_valid` is high. They also assume that a word-shift operation flagged as reserved has no defined result, so the sign-extension property skips it. The stimulus issues only defined codes. For the single reserved word shift it issues, it checks only the flag. The operands are chosen to exercise the edges: carries out of bit 63 and out of bit 31, shift amounts with bits above the legal field set, and upper halves filled with garbage under word operations.

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [3:0]      op_sel,
  input  logic            use_imm,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [11:0]     imm12,
  input  logic [19:0]     imm20,
  input  logic [XLEN-1:0] pc,
  output logic            out_valid,
  output logic [XLEN-1:0] result,
  output logic            reserved
);
  localparam int HW  = XLEN / 2;
  localparam int SW  = $clog2(XLEN);
  localparam int SWW = $clog2(HW);

  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_SLL = 4'd2, OP_SRL = 4'd3,
                         OP_SRA = 4'd4, OP_ADDW = 4'd5, OP_SUBW = 4'd6, OP_SLLW = 4'd7,
                         OP_SRLW = 4'd8, OP_SRAW = 4'd9, OP_LUI = 4'd10, OP_AUIPC = 4'd11;

  logic [XLEN-1:0] opb, upper, nxt;
  logic [HW-1:0]   wa, wb, wres;
  logic            arith, word_op, word_shift, rsv_nxt;

  assign opb        = use_imm ? {{(XLEN-12){imm12[11]}}, imm12} : src_b;
  assign wa         = src_a[HW-1:0];
  assign wb         = opb[HW-1:0];
  assign upper      = {{(XLEN-HW){imm20[19]}}, imm20, {(HW-20){1'b0}}};
  assign arith      = use_imm ? imm12[10] : (op_sel == OP_SRA || op_sel == OP_SRAW);
  assign word_op    = op_sel inside {OP_ADDW, OP_SUBW, OP_SLLW, OP_SRLW, OP_SRAW};
  assign word_shift = op_sel inside {OP_SLLW, OP_SRLW, OP_SRAW};
  assign rsv_nxt    = word_shift && use_imm && imm12[5];

  always_comb begin
    wres = '0;
    case (op_sel)
      OP_ADDW: wres = wa + wb;
      OP_SUBW: wres = wa - wb;
      OP_SLLW: wres = wa << wb[SWW-1:0];
      OP_SRLW, OP_SRAW:
        wres = arith ? HW'($signed(wa) >>> wb[SWW-1:0]) : (wa >> wb[SWW-1:0]);
      default: wres = '0;
    endcase
  end

  always_comb begin
    case (op_sel)
      OP_ADD:   nxt = src_a + opb;
      OP_SUB:   nxt = src_a - opb;
      OP_SLL:   nxt = src_a << opb[SW-1:0];
      OP_SRL, OP_SRA:
        nxt = arith ? XLEN'($signed(src_a) >>> opb[SW-1:0]) : (src_a >> opb[SW-1:0]);
      OP_LUI:   nxt = upper;
      OP_AUIPC: nxt = upper + pc;
      default:  nxt = word_op ? {{(XLEN-HW){wres[HW-1]}}, wres} : '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      reserved  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= nxt;
        reserved <= rsv_nxt;
      end
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r4_word_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && word_op && !rsv_nxt) |=> (&result[XLEN-1:HW-1] || ~|result[XLEN-1:HW-1]));
  a_r8_lui_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_LUI) |=> (result[11:0] == 12'd0));
  a_r10_sext_word: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_ADDW && use_imm && imm12 == 12'd0)
      |=> (result == {{(XLEN-HW){$past(src_a[HW-1])}}, $past(src_a[HW-1:0])}));
  a_r11_reserved_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && word_shift && use_imm && imm12[5]) |=> reserved);
  a_r11_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !word_shift) |=> !reserved);
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
endmodule

// File: tb/sim_int_exec_unit.sv
module sim_int_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op_sel = '0;
  logic        use_imm = 1'b0;
  logic [63:0] src_a = '0, src_b = '0, pc = '0;
  logic [11:0] imm12 = '0;
  logic [19:0] imm20 = '0;
  logic        out_valid, reserved;
  logic [63:0] result;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic [63:0] exp;
    logic        exp_rsv;
    bit          chk_res;
    string       req;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  int_exec_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel), .use_imm(use_imm),
    .src_a(src_a), .src_b(src_b), .imm12(imm12), .imm20(imm20), .pc(pc),
    .out_valid(out_valid), .result(result), .reserved(reserved)
  );

  function automatic logic [63:0] model(input logic [3:0] op, input logic [63:0] a,
      input logic [63:0] b, input logic ui, input logic [11:0] i12,
      input logic [19:0] i20, input logic [63:0] p);
    logic [63:0] bb, u;
    logic [31:0] w;
    bit ar;
    bb = ui ? {{52{i12[11]}}, i12} : b;
    u  = {{32{i20[19]}}, i20, 12'h000};
    ar = ui ? i12[10] : (op == 4'd4 || op == 4'd9);
    w  = '0;
    case (op)
      4'd0: return a + bb;
      4'd1: return a - bb;
      4'd2: return a << bb[5:0];
      4'd3, 4'd4: return ar ? 64'($signed(a) >>> bb[5:0]) : a >> bb[5:0];
      4'd5: w = a[31:0] + bb[31:0];
      4'd6: w = a[31:0] - bb[31:0];
      4'd7: w = a[31:0] << bb[4:0];
      4'd8, 4'd9: w = ar ? 32'($signed(a[31:0]) >>> bb[4:0]) : a[31:0] >> bb[4:0];
      4'd10: return u;
      4'd11: return u + p;
      default: return 64'd0;
    endcase
    return {{32{w[31]}}, w};
  endfunction

  task automatic issue(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
      input logic ui, input logic [11:0] i12, input logic [19:0] i20,
      input logic [63:0] p, input string req);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; src_a = a; src_b = b; use_imm = ui;
    imm12 = i12; imm20 = i20; pc = p;
    it.exp     = model(op, a, b, ui, i12, i20, p);
    it.exp_rsv = (op >= 4'd7 && op <= 4'd9 && ui && i12[5]);
    it.chk_res = !it.exp_rsv;
    it.req     = req;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    src_a = 64'hdead_beef_dead_beef; op_sel = 4'd1;
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R1: unexpected out_valid, act=1 exp=0");
      end else begin
        item_t it;
        it = sb.pop_front();
        n_tests++;
        if ((it.chk_res && result !== it.exp) || reserved !== it.exp_rsv) begin
          n_fail++;
          $display("FAIL %s: act=%h rsv=%b exp=%h rsv=%b", it.req, result, reserved,
                   it.exp, it.exp_rsv);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0 || result !== 64'd0 || reserved !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: act=%b/%h exp=0/0", out_valid, result);
    end
    rst_n = 1'b1;
    // R2 add/sub wrap
    issue(4'd0, 64'hffff_ffff_ffff_ffff, 64'd1, 0, 0, 0, 0, "R2");
    issue(4'd1, 64'd5, 64'd7, 0, 0, 0, 0, "R2");
    // R3 full shifts, amount from b[5:0]
    issue(4'd2, 64'h1, 64'd65, 0, 0, 0, 0, "R3");
    issue(4'd3, 64'h8000_0000_0000_0000, 64'hff3f, 0, 0, 0, 0, "R3");
    issue(4'd4, 64'h8000_0000_0000_0000, 64'd4, 0, 0, 0, 0, "R3");
    // R7 immediate operand and imm[10] choosing arithmetic
    issue(4'd0, 64'd10, 64'd999, 1, 12'hffe, 0, 0, "R7");
    issue(4'd3, 64'h8000_0000_0000_0000, 0, 1, 12'h404, 0, 0, "R7");
    issue(4'd4, 64'h8000_0000_0000_0000, 0, 1, 12'h004, 0, 0, "R7");
    // R4/R5 word add/sub with garbage upper halves
    issue(4'd5, 64'h0000_0001_7fff_ffff, 64'hffff_0000_0000_0001, 0, 0, 0, 0, "R5");
    issue(4'd6, 64'habcd_0000_0000_0000, 64'h1234_5678_0000_0001, 0, 0, 0, 0, "R4");
    // R10 sign-extend via word add with zero immediate
    issue(4'd5, 64'h1234_5678_8000_0001, 0, 1, 12'h000, 0, 0, "R10");
    issue(4'd5, 64'hffff_ffff_7fff_fff0, 0, 1, 12'h000, 0, 0, "R10");
    // R6 word shifts, amount from b[4:0]
    issue(4'd7, 64'h1, 64'h3f, 0, 0, 0, 0, "R6");
    issue(4'd8, 64'hffff_ffff_8000_0000, 64'd31, 0, 0, 0, 0, "R6");
    issue(4'd8, 64'h0000_0000_8000_0000, 64'd32, 0, 0, 0, 0, "R6");
    issue(4'd9, 64'h0000_0000_8000_0000, 64'd4, 0, 0, 0, 0, "R6");
    issue(4'd8, 64'h0000_0000_8000_0000, 0, 1, 12'h404, 0, 0, "R7");
    // R8/R9 upper immediate
    issue(4'd10, 0, 0, 0, 0, 20'h80000, 0, "R8");
    issue(4'd10, 0, 0, 0, 0, 20'h12345, 0, "R8");
    issue(4'd11, 0, 0, 0, 0, 20'hfffff, 64'h1000, "R9");
    issue(4'd11, 0, 0, 0, 0, 20'h7ffff, 64'hffff_ffff_ffff_f000, "R9");
    // R11 reserved word-shift immediate
    issue(4'd7, 64'h1, 0, 1, 12'h021, 0, 0, "R11");
    issue(4'd7, 64'h1, 0, 1, 12'h01f, 0, 0, "R11");
    idle(1);
    // R12 hold while idle
    held = result;
    repeat (3) @(negedge clk);
    n_tests++;
    if (result !== held || out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R12: act=%h/%b exp=%h/0", result, out_valid, held);
    end
    n_tests++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R1: act=%0d pending exp=0", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule